// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block turns one data transfer into a series of address/length segments by following a chain of scatter-gather descriptors kept in a small descriptor memory. A controller pulses `start` with the byte address of the first descriptor, the total transfer length and a direction bit. The walker then reads descriptors one after another through a single-cycle-latency read port. For every descriptor with a nonzero byte count it offers one segment downstream on a valid/ready handshake, and it keeps a running count of the bytes still owed.

The walk ends in one of three ways. The length runs out, which is a success, and any descriptors left in the chain are never read. A descriptor marked as the chain's last is consumed while bytes are still owed, which is an error whose code depends on the direction. Or the descriptor table does not start on a 64-bit boundary, which is rejected before any read. Completion is a one-cycle `done` pulse, with a 6-bit code on `err_code` where zero means success.

The controller is a five-state machine. IDLE waits for `start`. FETCH reads the four 32-bit words of one descriptor. EVAL skips descriptors that carry no bytes. ISSUE holds a segment until downstream accepts it. DONE raises the completion pulse. The transitions are:
- start→FETCH, which is taken for an aligned table and a nonzero length.
- start→DONE, which is taken for a misaligned table or a zero length.
- fetched→EVAL.
- EVAL→ISSUE, for a nonzero count.
- EVAL→FETCH, for a zero count that is not last.
- EVAL→DONE, for a zero count that is last.
- accepted→DONE, when the length is used up or the descriptor is last.
- accepted→FETCH, otherwise.
- DONE→IDLE.

Top module: `sg_walker`

## Requirements
- R1: A descriptor is four consecutive 32-bit memory words, 16 bytes. Word 0 holds address bits 31:0, word 1 holds address bits 63:32, word 2 holds the byte count and word 3 holds the flags. Only flags bit 31 marks the last descriptor; all other flag bits have no effect. The next descriptor starts four words later.
- R2: Segments are offered in chain order. Each segment carries its descriptor's 64-bit address and a length equal to the smaller of the descriptor's count and the bytes still owed.
- R3: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` hold their values.
- R4: When an accepted segment uses up the remaining length, the walk completes with code 0 and no further descriptor words are read. That final segment, and only that one, shows `seg_last` high.
- R5: If a last-marked descriptor has been consumed with bytes still owed and `start_to_dev` was 1, the code is 7.
- R6: Under the same condition with `start_to_dev` at 0, the code is 8.
- R7: If the descriptor table's byte address has a nonzero value in bits 2:0, the walk completes with code 16, with no memory read and no segment.
- R8: A descriptor with a byte count of zero produces no segment.
- R9: A total length of zero completes with code 0, with no memory read and no segment.
- R10: `done` is high for exactly one cycle per walk. A `start` pulse while `busy` is high is ignored.
- R11: After reset, `busy`, `seg_valid`, `done` and `mem_rd_en` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled only while idle) |
| start_base | input | ADDR_W+2 | Byte address of the first descriptor |
| start_len | input | LEN_W | Total bytes to transfer |
| start_to_dev | input | 1 | 1: data flows toward the device; 0: from the device |
| busy | output | 1 | A walk is in progress |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_rd_addr | output | ADDR_W | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| seg_valid | output | 1 | A segment is offered |
| seg_ready | input | 1 | Downstream accepts the segment |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| seg_last | output | 1 | Segment ends the transfer |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 6 | Completion code, valid with `done` |

## Verification
The assertions watch, on every cycle, that an offered segment stays stable while it is stalled and that it never has zero length. They also check that `done` lasts a single cycle, that the completion code is one of the four legal values, and that descriptor reads never overlap a segment offer. What only the scenarios can show is the arithmetic and the chain order. That covers the clipping of the last segment, the skipping of zero-count descriptors, the exact number of descriptor words read before the walk stops, and the direction-dependent code when the chain runs short. The bench compares all of these against its own walk of the memory image.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int ENTRY_WORDS = 4;
    localparam int TERM_BIT    = 31;
    localparam int ERR_W       = 6;

    localparam logic [ERR_W-1:0] ERR_NONE     = 6'd0;
    localparam logic [ERR_W-1:0] ERR_UNDERRUN = 6'd7;
    localparam logic [ERR_W-1:0] ERR_OVERRUN  = 6'd8;
    localparam logic [ERR_W-1:0] ERR_ALIGN    = 6'd16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_ISSUE,
        ST_DONE
    } sgw_state_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] count;
        logic        last;
    } sgw_entry_t;
endpackage

// File: rtl/sgw_entry_fetch.sv
module sgw_entry_fetch
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_ptr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output sgw_entry_t        ent,
    output logic              ent_valid
);
    localparam int IDX_W = $clog2(ENTRY_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_WORDS - 1);
    localparam logic [IDX_W:0]   N_WORDS  = (IDX_W+1)'(ENTRY_WORDS);

    logic              busy_q;
    logic [IDX_W:0]    iss_q;
    logic              pend_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              last_q;
    logic              valid_q;

    assign rd_en   = busy_q && (iss_q < N_WORDS);
    assign rd_addr = ptr_q + ADDR_W'(iss_q[IDX_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            iss_q      <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            ptr_q      <= '0;
            valid_q    <= 1'b0;
        end else begin
            valid_q    <= 1'b0;
            pend_q     <= rd_en;
            pend_idx_q <= iss_q[IDX_W-1:0];
            if (pend_q && pend_idx_q == LAST_IDX) begin
                busy_q  <= 1'b0;
                valid_q <= 1'b1;
            end
            if (go) begin
                busy_q <= 1'b1;
                iss_q  <= '0;
                ptr_q  <= go_ptr;
            end else if (rd_en) begin
                iss_q <= iss_q + 1'b1;
            end
        end
    end

    // One capture register per data word of the descriptor
    for (genvar i = 0; i < ENTRY_WORDS - 1; i++) begin : g_word
        logic [31:0] w_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                w_q <= '0;
            else if (pend_q && pend_idx_q == IDX_W'(i))
                w_q <= rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= 1'b0;
        else if (pend_q && pend_idx_q == LAST_IDX)
            last_q <= rd_data[TERM_BIT];
    end

    assign ent.addr   = {g_word[1].w_q, g_word[0].w_q};
    assign ent.count  = g_word[2].w_q;
    assign ent.last   = last_q;
    assign ent_valid  = valid_q;
endmodule

// File: rtl/sgw_len_track.sv
module sgw_len_track #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             consume,
    input  logic [31:0]      ent_count,
    output logic [LEN_W-1:0] clip,
    output logic             exhausts
);
    logic [LEN_W-1:0] rem_q;

    assign clip     = (64'(ent_count) > 64'(rem_q)) ? rem_q : LEN_W'(ent_count);
    assign exhausts = (clip == rem_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem_q <= '0;
        else if (load)
            rem_q <= load_len;
        else if (consume)
            rem_q <= rem_q - clip;
    end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W+1:0] start_base,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              start_to_dev,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [63:0]       seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_last,
    output logic              done,
    output logic [ERR_W-1:0]  err_code
);
    localparam int BA_W = ADDR_W + 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_WORDS);

    sgw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              to_dev_q;
    logic [ERR_W-1:0]  err_q, err_d;
    logic              err_set;
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_ptr;
    logic              len_load;
    logic              consume;
    sgw_entry_t        ent;
    logic              ent_valid;
    logic [LEN_W-1:0]  clip;
    logic              exhausts;
    logic [ERR_W-1:0]  short_err;

    sgw_entry_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (fetch_go),
        .go_ptr    (fetch_ptr),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .rd_data   (mem_rd_data),
        .ent       (ent),
        .ent_valid (ent_valid)
    );

    sgw_len_track #(.LEN_W(LEN_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (len_load),
        .load_len  (start_len),
        .consume   (consume),
        .ent_count (ent.count),
        .clip      (clip),
        .exhausts  (exhausts)
    );

    assign short_err = to_dev_q ? ERR_UNDERRUN : ERR_OVERRUN;
    assign consume   = (state_q == ST_ISSUE) && seg_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            to_dev_q <= 1'b0;
            err_q    <= ERR_NONE;
        end else begin
            if (fetch_go)
                ptr_q <= fetch_ptr;
            if (state_q == ST_IDLE && start)
                to_dev_q <= start_to_dev;
            if (err_set)
                err_q <= err_d;
        end
    end

    // Next state and sequencing strobes
    always_comb begin
        state_d   = state_q;
        fetch_go  = 1'b0;
        fetch_ptr = ptr_q + STEP;
        len_load  = 1'b0;
        err_set   = 1'b0;
        err_d     = ERR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    len_load = 1'b1;
                    if (start_base[2:0] != 3'd0) begin
                        err_set = 1'b1;
                        err_d   = ERR_ALIGN;
                        state_d = ST_DONE;
                    end else if (start_len == '0) begin
                        err_set = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        fetch_go  = 1'b1;
                        fetch_ptr = start_base[BA_W-1:2];
                        state_d   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (ent_valid)
                    state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (ent.count != 32'd0) begin
                    state_d = ST_ISSUE;
                end else if (ent.last) begin
                    err_set = 1'b1;
                    err_d   = short_err;
                    state_d = ST_DONE;
                end else begin
                    fetch_go = 1'b1;
                    state_d  = ST_FETCH;
                end
            end
            ST_ISSUE: begin
                if (seg_ready) begin
                    if (exhausts) begin
                        err_set = 1'b1;
                        state_d = ST_DONE;
                    end else if (ent.last) begin
                        err_set = 1'b1;
                        err_d   = short_err;
                        state_d = ST_DONE;
                    end else begin
                        fetch_go = 1'b1;
                        state_d  = ST_FETCH;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        seg_valid = (state_q == ST_ISSUE);
        done      = (state_q == ST_DONE);
        seg_addr  = ent.addr;
        seg_len   = clip;
        seg_last  = exhausts;
        err_code  = err_q;
    end
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mem_rd_en,
    input logic             seg_valid,
    input logic             seg_ready,
    input logic [63:0]      seg_addr,
    input logic [LEN_W-1:0] seg_len,
    input logic             seg_last,
    input logic             done,
    input logic [5:0]       err_code
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr)
                                    && $stable(seg_len) && $stable(seg_last));

    assert_nonzero_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_len != '0);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_code_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 6'd0 || err_code == 6'd7
                  || err_code == 6'd8 || err_code == 6'd16));

    assert_fetch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy && !seg_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !seg_valid && !mem_rd_en && !done);
endmodule

bind sg_walker sgw_checker #(.LEN_W(LEN_W)) u_sgw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_last  (seg_last),
    .done      (done),
    .err_code  (err_code)
);

// File: tb/tb_sg_walker.sv
module tb_sg_walker;
    localparam int AW = 6;
    localparam int LW = 32;
    localparam int NV = 11;

    // base, total, to_dev, expected code, ready pattern, mid-walk start poke
    localparam int V_BASE [NV] = '{0,   0,   0,   0,   64, 64, 96, 4,  66, 0, 0};
    localparam int V_LEN  [NV] = '{180, 120, 200, 200, 40, 41, 10, 10, 2,  0, 100};
    localparam int V_DIR  [NV] = '{1,   0,   1,   0,   0,  1,  0,  1,  0,  1, 1};
    localparam int V_ERR  [NV] = '{0,   0,   7,   8,   0,  7,  8,  16, 16, 0, 0};
    localparam int V_RDY  [NV] = '{0,   1,   2,   0,   1,  0,  0,  0,  0,  0, 2};
    localparam int V_POKE [NV] = '{1,   0,   0,   0,   0,  0,  0,  0,  0,  0, 0};

    logic            clk = 0;
    logic            rst_n = 0;
    logic            start = 0;
    logic [AW+1:0]   start_base = '0;
    logic [LW-1:0]   start_len = '0;
    logic            start_to_dev = 0;
    logic            busy, mem_rd_en, seg_valid, seg_last, done;
    logic            seg_ready = 0;
    logic [AW-1:0]   mem_rd_addr;
    logic [31:0]     mem_rd_data = '0;
    logic [63:0]     seg_addr;
    logic [LW-1:0]   seg_len;
    logic [5:0]      err_code;

    logic [31:0] mem [64];
    int checks = 0;
    int fails  = 0;

    int          m_n, m_err, m_reads;
    logic [63:0] m_addr [16];
    logic [31:0] m_len  [16];

    always #5 clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    sg_walker #(.ADDR_W(AW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
        .start_len(start_len), .start_to_dev(start_to_dev), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .done(done), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected walk computed from the descriptor layout rules
    task automatic model(input int base, input int total, input int to_dev);
        int ptr, rem;
        logic [31:0] c, f;
        m_n = 0; m_err = 0; m_reads = 0;
        if ((base % 8) != 0) begin
            m_err = 16;
        end else if (total != 0) begin
            ptr = base / 4;
            rem = total;
            for (int e = 0; e < 16; e++) begin
                m_reads += 4;
                c = mem[(ptr + 2) % 64];
                f = mem[(ptr + 3) % 64];
                if (c != 0) begin
                    m_addr[m_n] = {mem[(ptr + 1) % 64], mem[ptr % 64]};
                    m_len[m_n]  = (c < rem) ? c : rem;
                    rem -= int'(m_len[m_n]);
                    m_n++;
                    if (rem == 0) begin m_err = 0; break; end
                end
                if (f[31]) begin m_err = to_dev ? 7 : 8; break; end
                ptr += 4;
            end
        end
    endtask

    task automatic run_xfer(input int vi);
        int nseg = 0, reads = 0, waited = 0;
        bit got_done = 0, held = 0;
        logic [63:0] h_addr;
        logic [LW-1:0] h_len;
        model(V_BASE[vi], V_LEN[vi], V_DIR[vi]);
        @(negedge clk);
        start = 1; start_base = (AW+2)'(V_BASE[vi]);
        start_len = LW'(V_LEN[vi]); start_to_dev = V_DIR[vi][0];
        @(negedge clk);
        start = 0;
        while (!got_done && waited < 3000) begin
            seg_ready = (V_RDY[vi] == 0) ? 1'b1 : ((waited % (V_RDY[vi] + 1)) == V_RDY[vi]);
            if (V_POKE[vi] != 0 && waited == 3) begin
                start = 1; start_base = '0; start_len = 5; start_to_dev = 0;
            end else begin
                start = 0;
            end
            #1;
            if (held) begin
                chk(seg_valid && seg_addr == h_addr && seg_len == h_len,
                    "R3 stalled segment held", seg_len, h_len);
                held = 0;
            end
            if (mem_rd_en) reads++;
            if (seg_valid && seg_ready) begin
                if (nseg < m_n) begin
                    chk(seg_addr == m_addr[nseg], "R1 R2 segment address", seg_addr, m_addr[nseg]);
                    chk(seg_len == m_len[nseg], "R2 segment length", seg_len, m_len[nseg]);
                    chk(seg_last == (nseg == m_n - 1 && m_err == 0), "R4 seg_last flag",
                        seg_last, (nseg == m_n - 1 && m_err == 0));
                end
                nseg++;
            end else if (seg_valid) begin
                held = 1; h_addr = seg_addr; h_len = seg_len;
            end
            if (done) begin
                got_done = 1;
                chk(err_code == 6'(V_ERR[vi]), "R5 R6 R7 R9 completion code", err_code, V_ERR[vi]);
            end
            @(negedge clk);
            waited++;
        end
        start = 0;
        chk(got_done, "R10 walk completes", got_done, 1);
        chk(!done, "R10 done lasts one cycle", done, 0);
        chk(nseg == m_n, "R2 R8 segment count", nseg, m_n);
        chk(reads == m_reads, "R4 R7 descriptor words read", reads, m_reads);
        chk(m_err == V_ERR[vi], "R5 R6 model agrees with table", m_err, V_ERR[vi]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        // chain A at byte 0: four descriptors, second has zero count
        mem[0]  = 32'h0000_1000; mem[1]  = 32'h0000_0001; mem[2]  = 32'd100; mem[3]  = 32'h7FFF_FFFF;
        mem[4]  = 32'hDEAD_0000; mem[5]  = 32'h0;         mem[6]  = 32'd0;   mem[7]  = 32'h0;
        mem[8]  = 32'h0002_0000; mem[9]  = 32'h0000_0002; mem[10] = 32'd50;  mem[11] = 32'h0000_0001;
        mem[12] = 32'h0003_0040; mem[13] = 32'h0000_0003; mem[14] = 32'd30;  mem[15] = 32'h8000_0000;
        // chain B at byte 64: single last descriptor, followed by one that must be ignored
        mem[16] = 32'h0004_0000; mem[17] = 32'h0;         mem[18] = 32'd40;  mem[19] = 32'h8000_0000;
        mem[20] = 32'h0005_0000; mem[21] = 32'h0;         mem[22] = 32'd99;  mem[23] = 32'h0;
        // chain C at byte 96: last descriptor with zero count
        mem[24] = 32'h0006_0000; mem[25] = 32'h0;         mem[26] = 32'd0;   mem[27] = 32'h8000_0000;

        repeat (3) @(negedge clk);
        chk(!busy && !seg_valid && !done && !mem_rd_en && err_code == 0,
            "R11 reset state", {busy, seg_valid, done, mem_rd_en}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_rd_en, "R11 idle after reset release", busy, 0);

        for (int v = 0; v < NV; v++) run_xfer(v);

        // directed: reset in the middle of a walk returns to idle
        @(negedge clk);
        start = 1; start_base = '0; start_len = 180; start_to_dev = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        rst_n = 0;
        #1;
        chk(!busy && !seg_valid && !done && err_code == 0, "R11 reset mid-walk", busy, 0);
        @(negedge clk);
        rst_n = 1;
        run_xfer(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule